// File: doc/BRIEF.md
# Memory Map Discovery Classifier

This block is a bus master that works out what kind of storage sits behind each part of a byte-wide address space. It visits the space one aligned 64-byte block at a time. On every block it runs non-destructive write/read-back probes and then labels the block as read/write memory, read-only memory, an input/output register area, or nothing worth reporting. The contents each location held before the probe are written back before the engine moves on.

Software or a test controller issues a start command with an inclusive first and last block index. The engine then drives a simple synchronous memory port: one request at a time, held until the target raises ready. For every block in the range it offers one result record on a valid/ready stream. Back-pressure rules are simple. A record stays on the outputs unchanged until `rec_ready` is sampled high with `rec_valid`. While a record waits, the engine issues no memory access. `rec_ready` may be held high at all times. A record is accepted on the clock edge where both signals are high, and the next block's probing starts after that edge.

Per location, the probe reads the original byte, writes and reads back 8'h55, writes and reads back 8'hAA, and then restores the original byte. A bit counts as writeable at that location only if both read-backs matched. Blocks whose bits are writeable everywhere then get a distinctness pass. That pass fills each offset with the offset XOR 8'hA5, reads all 64 locations back, and restores them. Blocks with no writeable bit are scanned for a value that occurs exactly once.

Top module: `memmap_probe`

## Requirements
- R1: One record is produced for each block from `first_blk` to `last_blk` inclusive, in increasing order. Each record's `rec_base` equals the block index times 64.
- R2: A block in which every bit of every location passes both read-backs, and all 64 locations keep their distinct fill values, is reported with class 2'b01 and mask 8'hFF. This holds whatever the block held beforehand, all-zero contents included.
- R3: A block with no writeable bit is reported with class 2'b10 and mask 8'h00 when at least one of its 64 original values occurs exactly once in the block and no rejection rule of R5 or R6 applies.
- R4: A block with at least one bit writeable at every location that does not meet R2 is reported with class 2'b11. Its mask holds exactly the bits that are writeable at all 64 locations. This covers a block that aliases onto itself, which has mask 8'hFF.
- R5: A block with no writeable bit whose original data is 8'h00 at every location, or 8'hFF at every location, is reported with class 2'b00 and mask 8'h00.
- R6: A block with no writeable bit whose original data equals the low byte of its own address at every location is reported with class 2'b00 and mask 8'h00.
- R7: A block with no writeable bit and no value occurring exactly once is reported with class 2'b00. So is a block whose writeable bits are not writeable at every location. Both carry mask 8'h00.
- R8: After a run, every probed location reads back the value it returned before the run.
- R9: `mem_we` and `mem_re` are never high together. While either is high and `mem_ready` is low, `mem_addr`, `mem_wdata`, `mem_we` and `mem_re` hold their values.
- R10: While `rec_valid` is high and `rec_ready` is low, `rec_valid`, `rec_base`, `rec_class` and `rec_mask` hold their values. No memory request is issued while `rec_valid` is high.
- R11: `busy` rises the cycle after an accepted start and falls on the edge that accepts the last record. `done` is high for exactly that one following cycle. A start seen while `busy` is high is ignored.
- R12: A start with `first_blk` greater than `last_blk` produces no record and leaves `busy` low. `done` pulses for one cycle.
- R13: During and right after reset, `busy`, `done`, `rec_valid`, `mem_we` and `mem_re` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start command, sampled while idle |
| first_blk | input | ADDR_W-6 | First block index of the range |
| last_blk | input | ADDR_W-6 | Last block index of the range (inclusive) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| mem_addr | output | ADDR_W | Byte address of the current request |
| mem_wdata | output | DATA_W | Write data |
| mem_we | output | 1 | Write request |
| mem_re | output | 1 | Read request |
| mem_rdata | input | DATA_W | Read data, valid in the cycle `mem_ready` completes a read |
| mem_ready | input | 1 | Completes the current request at this edge |
| rec_valid | output | 1 | Result record offered |
| rec_ready | input | 1 | Result record accepted |
| rec_base | output | ADDR_W | Base byte address of the block |
| rec_class | output | 2 | 00 none, 01 RAM, 10 ROM, 11 I/O |
| rec_mask | output | DATA_W | Bits writeable at every location of the block |

## Verification
The bench models sixteen blocks, each built to a different behaviour, and sweeps them under random wait states and record back-pressure:
- Plain RAM blocks, one of them all-zero, show that writeability outranks the trivial-pattern rules.
- Hashed ROM and nearly-constant ROM with a single odd value separate the unique-value rule from the constant ROM that must be dropped.
- All-zero, all-ones and address-echo data each exercise one rejection rule, and an echo block with one corrupted location shows that a near-miss is still reported.
- Partially writeable registers with masks 0x0F, 0x81 and 0x80, a half-size block mirrored onto itself, and a block with one bit writeable at a single location separate the I/O rule from RAM and from unreported blocks.
- Single-block, sub-range, empty and mid-run restart commands cover the range and control rules, and a snapshot of every read value shows the contents were restored.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  typedef enum logic [1:0] {
    CLS_NONE = 2'b00,
    CLS_RAM  = 2'b01,
    CLS_ROM  = 2'b10,
    CLS_IO   = 2'b11
  } blk_class_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_A_RD0,
    S_A_WR1,
    S_A_RD1,
    S_A_WR2,
    S_A_RD2,
    S_A_WRR,
    S_B_WR,
    S_C_RD,
    S_D_WR,
    S_UNIQ,
    S_EMIT
  } probe_state_t;

endpackage

// File: rtl/memmap_loc_buf.sv
// Holds the original byte of every location of the block being probed.
module memmap_loc_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] all_q [DEPTH]
);

  logic [DATA_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_idx] <= wr_data;
  end

  assign rd_data = store_q[rd_idx];

  for (genvar k = 0; k < DEPTH; k++) begin : g_out
    assign all_q[k] = store_q[k];
  end

endmodule

// File: rtl/memmap_uniq.sv
// Reports whether the value at one index occurs exactly once in the set.
module memmap_uniq #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DATA_W-1:0] vals [DEPTH],
  input  logic [IDX_W-1:0]  idx,
  output logic              single
);

  logic [DATA_W-1:0] probe_v;
  logic [DEPTH-1:0]  hit;

  assign probe_v = vals[idx];

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    assign hit[k] = (vals[k] == probe_v);
  end

  assign single = ($countones(hit) == 1);

endmodule

// File: rtl/memmap_classify.sv
// Turns the accumulated probe evidence into a class code and mask.
module memmap_classify
  import memmap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] wr_all,
  input  logic [DATA_W-1:0] wr_any,
  input  logic              distinct,
  input  logic              uniq_seen,
  input  logic              all_zero,
  input  logic              all_one,
  input  logic              all_echo,
  output blk_class_t        cls,
  output logic [DATA_W-1:0] mask
);

  logic is_ram, is_io, is_rom, trivial;

  always_comb begin
    trivial = all_zero | all_one | all_echo;
    is_ram  = (wr_all == {DATA_W{1'b1}}) && distinct;
    is_io   = !is_ram && (wr_all != '0);
    is_rom  = (wr_any == '0) && uniq_seen && !trivial;
    if (is_ram)      cls = CLS_RAM;
    else if (is_io)  cls = CLS_IO;
    else if (is_rom) cls = CLS_ROM;
    else             cls = CLS_NONE;
    mask = (is_ram || is_io) ? wr_all : '0;
  end

endmodule

// File: rtl/memmap_probe.sv
module memmap_probe
  import memmap_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int BLK_BYTES = 64,
  localparam int OFS_W    = $clog2(BLK_BYTES),
  localparam int BLK_W    = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BLK_W-1:0]  first_blk,
  input  logic [BLK_W-1:0]  last_blk,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [ADDR_W-1:0] rec_base,
  output logic [1:0]        rec_class,
  output logic [DATA_W-1:0] rec_mask
);

  localparam logic [DATA_W-1:0] ONES   = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] PAT_LO = {(DATA_W/2){2'b01}};
  localparam logic [DATA_W-1:0] PAT_HI = ~PAT_LO;
  localparam logic [DATA_W-1:0] SCRAM  = {(DATA_W/8){8'hA5}};
  localparam logic [OFS_W-1:0]  LOC_LAST = {OFS_W{1'b1}};

  probe_state_t      st;
  logic [BLK_W-1:0]  cur_q, last_q;
  logic [OFS_W-1:0]  loc_q;
  logic [DATA_W-1:0] rb1_q, wr_all_q, wr_any_q;
  logic              zero_q, one_q, echo_q, dist_q, uniq_q;
  logic              busy_q, done_q;

  logic              xfer, loc_end, blk_begin;
  logic [DATA_W-1:0] fill_v, loc_wm;
  logic [DATA_W-1:0] saved_v;
  logic [DATA_W-1:0] saved_all [BLK_BYTES];
  logic              single_hit;
  blk_class_t        cls;
  logic [DATA_W-1:0] cls_mask;

  assign xfer    = (mem_we | mem_re) & mem_ready;
  assign loc_end = (loc_q == LOC_LAST);
  assign fill_v  = DATA_W'(loc_q) ^ SCRAM;
  assign loc_wm  = ~(rb1_q ^ PAT_LO) & ~(mem_rdata ^ PAT_HI);

  // A new block starts on an accepted start or on acceptance of a
  // record that is not the last one.
  assign blk_begin = ((st == S_IDLE) && start && (first_blk <= last_blk)) ||
                     ((st == S_EMIT) && rec_ready && (cur_q != last_q));

  memmap_loc_buf #(.DATA_W(DATA_W), .DEPTH(BLK_BYTES)) u_buf (
    .clk     (clk),
    .wr_en   ((st == S_A_RD0) && xfer),
    .wr_idx  (loc_q),
    .wr_data (mem_rdata),
    .rd_idx  (loc_q),
    .rd_data (saved_v),
    .all_q   (saved_all)
  );

  memmap_uniq #(.DATA_W(DATA_W), .DEPTH(BLK_BYTES)) u_uniq (
    .vals   (saved_all),
    .idx    (loc_q),
    .single (single_hit)
  );

  memmap_classify #(.DATA_W(DATA_W)) u_cls (
    .wr_all    (wr_all_q),
    .wr_any    (wr_any_q),
    .distinct  (dist_q),
    .uniq_seen (uniq_q),
    .all_zero  (zero_q),
    .all_one   (one_q),
    .all_echo  (echo_q),
    .cls       (cls),
    .mask      (cls_mask)
  );

  // Memory port, decoded from the state.
  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_wdata = '0;
    unique case (st)
      S_A_RD0, S_A_RD1, S_A_RD2, S_C_RD: mem_re = 1'b1;
      S_A_WR1: begin mem_we = 1'b1; mem_wdata = PAT_LO;  end
      S_A_WR2: begin mem_we = 1'b1; mem_wdata = PAT_HI;  end
      S_A_WRR, S_D_WR: begin mem_we = 1'b1; mem_wdata = saved_v; end
      S_B_WR:  begin mem_we = 1'b1; mem_wdata = fill_v;  end
      default: ;
    endcase
  end

  assign mem_addr  = {cur_q, loc_q};
  assign rec_valid = (st == S_EMIT);
  assign rec_base  = {cur_q, {OFS_W{1'b0}}};
  assign rec_class = cls;
  assign rec_mask  = cls_mask;
  assign busy      = busy_q;
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_q    <= '0;
      last_q   <= '0;
      loc_q    <= '0;
      rb1_q    <= '0;
      wr_all_q <= ONES;
      wr_any_q <= '0;
      zero_q   <= 1'b1;
      one_q    <= 1'b1;
      echo_q   <= 1'b1;
      dist_q   <= 1'b1;
      uniq_q   <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (start) begin
            if (first_blk > last_blk) begin
              done_q <= 1'b1;
            end else begin
              cur_q  <= first_blk;
              last_q <= last_blk;
              busy_q <= 1'b1;
              st     <= S_A_RD0;
            end
          end
        end
        S_A_RD0: if (xfer) begin
          zero_q <= zero_q & (mem_rdata == '0);
          one_q  <= one_q & (mem_rdata == ONES);
          echo_q <= echo_q & (mem_rdata == mem_addr[DATA_W-1:0]);
          st     <= S_A_WR1;
        end
        S_A_WR1: if (xfer) st <= S_A_RD1;
        S_A_RD1: if (xfer) begin
          rb1_q <= mem_rdata;
          st    <= S_A_WR2;
        end
        S_A_WR2: if (xfer) st <= S_A_RD2;
        S_A_RD2: if (xfer) begin
          wr_all_q <= wr_all_q & loc_wm;
          wr_any_q <= wr_any_q | loc_wm;
          st       <= S_A_WRR;
        end
        S_A_WRR: if (xfer) begin
          loc_q <= loc_q + 1'b1;
          if (!loc_end)                 st <= S_A_RD0;
          else if (wr_all_q == ONES)    st <= S_B_WR;
          else if (wr_any_q == '0)      st <= S_UNIQ;
          else                          st <= S_EMIT;
        end
        S_B_WR: if (xfer) begin
          loc_q <= loc_q + 1'b1;
          if (loc_end) st <= S_C_RD;
        end
        S_C_RD: if (xfer) begin
          if (mem_rdata != fill_v) dist_q <= 1'b0;
          loc_q <= loc_q + 1'b1;
          if (loc_end) st <= S_D_WR;
        end
        S_D_WR: if (xfer) begin
          loc_q <= loc_q + 1'b1;
          if (loc_end) st <= S_EMIT;
        end
        S_UNIQ: begin
          if (single_hit) uniq_q <= 1'b1;
          loc_q <= loc_q + 1'b1;
          if (loc_end) st <= S_EMIT;
        end
        S_EMIT: if (rec_ready) begin
          if (cur_q == last_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            cur_q <= cur_q + 1'b1;
            st    <= S_A_RD0;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (blk_begin) begin
        loc_q    <= '0;
        wr_all_q <= ONES;
        wr_any_q <= '0;
        zero_q   <= 1'b1;
        one_q    <= 1'b1;
        echo_q   <= 1'b1;
        dist_q   <= 1'b1;
        uniq_q   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/memmap_probe_chk.sv
module memmap_probe_chk #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int BLK_BYTES = 64,
  localparam int OFS_W    = $clog2(BLK_BYTES),
  localparam int BLK_W    = ADDR_W - OFS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [BLK_W-1:0]  first_blk,
  input logic [BLK_W-1:0]  last_blk,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_we,
  input logic              mem_re,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              mem_ready,
  input logic              rec_valid,
  input logic              rec_ready,
  input logic [ADDR_W-1:0] rec_base,
  input logic [1:0]        rec_class,
  input logic [DATA_W-1:0] rec_mask
);

  p_one_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) && !mem_ready |=>
      $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we) && $stable(mem_re));

  p_rec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=>
      rec_valid && $stable(rec_base) && $stable(rec_class) && $stable(rec_mask));

  p_quiet_emit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> !mem_we && !mem_re);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_ram_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_class == 2'b01 |-> rec_mask == {DATA_W{1'b1}});

  p_rom_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_class == 2'b10 |-> rec_mask == '0);

  p_io_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_class == 2'b11 |-> rec_mask != '0);

  p_base_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_base[OFS_W-1:0] == '0);

endmodule

bind memmap_probe memmap_probe_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_BYTES(BLK_BYTES)
) u_chk (.*);

// File: tb/memmap_probe_bench.sv
module memmap_probe_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int BW = AW - 6;
  localparam int NLOC = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [BW-1:0] first_blk = '0, last_blk = '0;
  logic          busy, done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          mem_we, mem_re;
  logic          mem_ready = 1'b0;
  logic          rec_valid;
  logic          rec_ready = 1'b0;
  logic [AW-1:0] rec_base;
  logic [1:0]    rec_class;
  logic [DW-1:0] rec_mask;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit ended    = 1'b0;

  logic [DW-1:0] mem_arr [NLOC];
  logic [DW-1:0] snap    [NLOC];
  logic [15:0]   lfsr = 16'hACE1;

  int  exp_blk = 0;
  int  rec_cnt = 0;
  int  hs_errs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memmap_probe #(.ADDR_W(AW), .DATA_W(DW), .BLK_BYTES(64)) u_memmap_probe (
    .clk, .rst_n, .start, .first_blk, .last_blk, .busy, .done,
    .mem_addr, .mem_wdata, .mem_we, .mem_re, .mem_rdata, .mem_ready,
    .rec_valid, .rec_ready, .rec_base, .rec_class, .rec_mask
  );

  // Behavioural model of sixteen blocks, each of a different kind.
  function automatic logic [DW-1:0] rd_fn(input logic [AW-1:0] a);
    logic [3:0] b;
    logic [5:0] o;
    logic [DW-1:0] h;
    b = a[9:6];
    o = a[5:0];
    h = 8'(int'(a) * 37 + 11);
    case (b)
      4'd0, 4'd11, 4'd14: return mem_arr[a];
      4'd1, 4'd12: return h;
      4'd2:  return 8'h00;
      4'd3:  return 8'hFF;
      4'd4:  return a[7:0];
      4'd5:  return (mem_arr[a] & 8'h0F) | 8'hC0;
      4'd6:  return mem_arr[{b, 1'b0, o[4:0]}];
      4'd7:  return 8'h3C;
      4'd8:  return (o == 6'd17) ? 8'h12 : 8'h00;
      4'd9:  return (mem_arr[a] & 8'h81) | 8'h5A;
      4'd10: return (o == 6'd0) ? (8'h24 | (mem_arr[a] & 8'h01)) : 8'h24;
      4'd13: return (mem_arr[a] & 8'h80) | 8'h11;
      default: return (o == 6'd9) ? (a[7:0] ^ 8'h01) : a[7:0];
    endcase
  endfunction

  function automatic logic [AW-1:0] wr_idx(input logic [AW-1:0] a);
    if (a[9:6] == 4'd6) return {a[9:6], 1'b0, a[4:0]};
    return a;
  endfunction

  // Expected {class, mask} per block, from the requirements.
  function automatic logic [9:0] exp_rec(input int b);
    case (b)
      0, 11, 14:   return {2'b01, 8'hFF};
      1, 8, 12, 15: return {2'b10, 8'h00};
      5:  return {2'b11, 8'h0F};
      6:  return {2'b11, 8'hFF};
      9:  return {2'b11, 8'h81};
      13: return {2'b11, 8'h80};
      default: return {2'b00, 8'h00};
    endcase
  endfunction

  function automatic string req_of(input int b);
    case (b)
      0, 11, 14: return "R2";
      1, 8, 12, 15: return "R3";
      5, 6, 9, 13: return "R4";
      2, 3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  assign mem_rdata = rd_fn(mem_addr);

  always @(posedge clk) begin
    if (mem_we && mem_ready) mem_arr[wr_idx(mem_addr)] <= mem_wdata;
  end

  // Wait states and back-pressure, changed just after each edge.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = lfsr[0] | lfsr[3];
    rec_ready = lfsr[5] | lfsr[9];
  end

  // Record monitor and handshake monitor (R1, R9, R10).
  logic          p_req = 1'b0, p_rdy = 1'b0, p_we = 1'b0, p_vld = 1'b0, p_rrdy = 1'b0;
  logic [AW-1:0] p_addr = '0, p_base = '0;
  logic [DW-1:0] p_wd = '0, p_mask = '0;
  logic [1:0]    p_cls = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we && mem_re) hs_errs++;
      if (p_req && !p_rdy && ((mem_addr != p_addr) || (mem_we != p_we) ||
          (mem_wdata != p_wd) || !(mem_we || mem_re))) hs_errs++;
      if (p_vld && !p_rrdy && (!rec_valid || rec_base != p_base ||
          rec_class != p_cls || rec_mask != p_mask)) hs_errs++;
      if (rec_valid && (mem_we || mem_re)) hs_errs++;
      if (rec_valid && rec_ready) begin
        n_checks++;
        if (rec_base != AW'(exp_blk * 64)) begin
          n_fails++;
          $display("FAIL R1 record base got %h expected %h", rec_base, AW'(exp_blk * 64));
        end
        n_checks++;
        if ({rec_class, rec_mask} != exp_rec(exp_blk)) begin
          n_fails++;
          $display("FAIL %s block %0d class/mask got %h expected %h",
                   req_of(exp_blk), exp_blk, {rec_class, rec_mask}, exp_rec(exp_blk));
        end
        exp_blk++;
        rec_cnt++;
      end
    end
    p_req = mem_we || mem_re; p_rdy = mem_ready; p_we = mem_we;
    p_addr = mem_addr; p_wd = mem_wdata;
    p_vld = rec_valid; p_rrdy = rec_ready; p_base = rec_base;
    p_cls = rec_class; p_mask = rec_mask;
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] expv);
    n_checks++;
    if (got !== expv) begin
      n_fails++;
      $display("FAIL %s got %0h expected %0h", req, got, expv);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  endtask

  // Runs one range; optionally pulses a second start mid-run (R11).
  task automatic run(input int f, input int l, input bit poke);
    @(negedge clk);
    first_blk = BW'(f); last_blk = BW'(l); start = 1'b1;
    exp_blk = f; rec_cnt = 0;
    @(negedge clk);
    start = 1'b0;
    first_blk = '0; last_blk = '0;
    chk("R11 busy after start", busy, 1);
    if (poke) begin
      repeat (300) @(negedge clk);
      first_blk = BW'(0); last_blk = BW'(0); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R11 busy kept after ignored start", busy, 1);
    end
    while (!done) @(negedge clk);
    chk("R11 busy low at done", busy, 0);
    chk("R1 record count", rec_cnt, l - f + 1);
    @(negedge clk);
    chk("R11 done one cycle", done, 0);
  endtask

  initial begin
    for (int a = 0; a < NLOC; a++) begin
      if (a[9:6] == 4'd14) mem_arr[a] = 8'h00;
      else if (a[9:6] == 4'd0 || a[9:6] == 4'd11) mem_arr[a] = 8'(a * 3 + 1);
      else mem_arr[a] = 8'(a) ^ 8'h5A;
    end
    for (int a = 0; a < NLOC; a++) snap[a] = rd_fn(AW'(a));

    repeat (3) @(negedge clk);
    chk("R13 busy in reset", busy, 0);
    chk("R13 done in reset", done, 0);
    chk("R13 rec_valid in reset", rec_valid, 0);
    chk("R13 mem request in reset", {mem_we, mem_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 idle after reset", {busy, done, rec_valid, mem_we, mem_re}, 0);

    run(0, 15, 1'b0);
    run(5, 5, 1'b0);
    run(3, 9, 1'b1);

    // Empty range (R12).
    @(negedge clk);
    first_blk = BW'(7); last_blk = BW'(6); start = 1'b1; rec_cnt = 0;
    @(negedge clk);
    start = 1'b0;
    chk("R12 done pulse on empty range", done, 1);
    chk("R12 busy stays low", busy, 0);
    repeat (5) @(negedge clk);
    chk("R12 no record", rec_cnt, 0);
    chk("R12 done dropped", done, 0);

    // Contents restored (R8), one check per block.
    for (int b = 0; b < 16; b++) begin
      int bad = 0;
      for (int o = 0; o < 64; o++)
        if (rd_fn(AW'(b * 64 + o)) != snap[b * 64 + o]) bad++;
      chk($sformatf("R8 block %0d mismatching locations", b), bad, 0);
    end
    chk("R9 R10 handshake violations", hs_errs, 0);
    finish_run();
  end

  always @(negedge clk) begin
    if (cyc > 150000 && !ended) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired got %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

endmodule